// File: doc/BRIEF.md
# Streaming Bit-Reversal Reorder Buffer

This block sits in front of a radix-2 transform pipeline. It receives a continuous stream of complex samples, C samples per chunk, and returns each block of M = 2^NU samples in bit-reversed index order. Two block-sized banks work in alternation. While one bank fills with the incoming block, the other bank is read back through reversed addresses, so each chunk accepted during block b > 0 releases one reordered chunk of block b-1.

A start pulse latches the number of blocks to process. The first block produces no output. After the final input chunk, the block drains the last block on its own, with its input side closed, and then raises a done level. Output therefore trails input by exactly one block, and the total output chunk count equals the total input chunk count.

The controller has five states. IDLE waits after reset. FILL takes in block 0. SWAP writes one bank and reads the other. FLUSH drains the last block. DONE marks completion. The transitions are: IDLE/DONE to FILL on start with a nonzero count, and IDLE/DONE to DONE on start with a zero count. FILL to SWAP, or FILL to FLUSH when only one block was requested, happens on the last chunk of block 0. SWAP to FLUSH happens on the last chunk of the final block. FLUSH to DONE happens when the last drained chunk is accepted.

Top module: `brev_stream`

## Requirements
- R1: After reset, in_ready, out_valid and done are all 0.
- R2: Sample s of a chunk occupies bits [s*DW +: DW] of the chunk bus. Within a block, chunk q carries sample indices q*C to q*C+C-1. Output lane j of output chunk q equals the input sample of the same block whose NU-bit index is q*C+j with its bits reversed (index bit 0 goes to bit NU-1, and so on).
- R3: While block 0 is being received, in_ready is 1 and out_valid stays 0.
- R4: While blocks after the first are received, out_valid follows in_valid and in_ready follows out_ready. Exactly one output chunk leaves for each input chunk taken.
- R5: After the last input chunk, the M/C chunks of the final block are emitted in order with in_ready held at 0.
- R6: A run of N blocks emits exactly N*M/C chunks. done rises after the last of these is accepted, stays at 1 until the next start, and drops when a new run starts.
- R7: A start with num_blocks = 0 raises done on the next cycle and emits nothing.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds its value.
- R9: A start pulse during FILL, SWAP or FLUSH has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; latches num_blocks |
| num_blocks | input | BW | Number of blocks in the run |
| in_valid | input | 1 | Input chunk valid |
| in_ready | output | 1 | Input chunk accepted when high with in_valid |
| in_data | input | C*DW | Input chunk, sample 0 in the low bits |
| out_valid | output | 1 | Output chunk valid |
| out_ready | input | 1 | Downstream accepts the chunk |
| out_data | output | C*DW | Reordered output chunk |
| done | output | 1 | Run complete |

## Verification
The bench runs with one block, several blocks, and several blocks with input gaps, random backpressure and a stray start pulse. A scoreboard holds reversed-index chunks built from a model. Each sample carries its own index, so a wrong bank choice, a missing address reversal or a lane swap shows up as a mismatch, and a ping-pong error shows up as data from the wrong block. It also checks the edges of a run. Output during block 0, an input taken during the drain, a missing or extra drained chunk, an honoured mid-run start and a zero-count start that hangs instead of finishing all change the output count or the done timing. Data that shifts during a stall breaks the hold check.

// File: rtl/brr_pkg.sv
package brr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_SWAP,
        ST_FLUSH,
        ST_DONE
    } brr_state_e;

    // Reverse the low n bits of v (n <= 16)
    function automatic logic [15:0] rev_bits(input logic [15:0] v, input int n);
        logic [15:0] r;
        r = '0;
        for (int i = 0; i < 16; i++) begin
            if (i < n) r[n-1-i] = v[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/brr_ctrl.sv
module brr_ctrl
    import brr_pkg::*;
#(
    parameter int NU  = 4,
    parameter int ETA = 1,
    parameter int BW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BW-1:0]     num_blocks,
    input  logic              in_valid,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic              done,
    output logic              wr_en,
    output logic              wr_bank,
    output logic              rd_bank,
    output logic [NU-ETA-1:0] chunk_idx
);
    localparam int IW  = NU - ETA;
    localparam int CPB = 1 << IW;

    brr_state_e      state, nxt;
    logic [IW-1:0]   idx;
    logic            bank;
    logic [BW-1:0]   blk_left;
    logic            in_fire, out_fire, last, step, idle_like;

    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;
    assign last      = (idx == IW'(CPB - 1));
    assign idle_like = (state == ST_IDLE) || (state == ST_DONE);
    assign step      = (state == ST_FLUSH) ? out_fire
                     : ((state == ST_FILL) || (state == ST_SWAP)) ? in_fire : 1'b0;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (start) nxt = (num_blocks == '0) ? ST_DONE : ST_FILL;
            end
            ST_FILL, ST_SWAP: begin
                if (in_fire && last) nxt = (blk_left == BW'(1)) ? ST_FLUSH : ST_SWAP;
            end
            ST_FLUSH: begin
                if (out_fire && last) nxt = ST_DONE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_FILL:  in_ready = 1'b1;
            ST_SWAP: begin
                in_ready  = out_ready;
                out_valid = in_valid;
            end
            ST_FLUSH: out_valid = 1'b1;
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            bank     <= 1'b0;
            blk_left <= '0;
        end else if (idle_like && start) begin
            idx      <= '0;
            blk_left <= num_blocks;
        end else if (step) begin
            idx <= idx + 1'b1;
            if (last && state != ST_FLUSH) begin
                bank     <= ~bank;
                blk_left <= blk_left - 1'b1;
            end
        end
    end

    assign wr_en     = in_fire;
    assign wr_bank   = bank;
    assign rd_bank   = ~bank;
    assign chunk_idx = idx;

    a_r3_silent_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> !out_valid);

    a_r4_one_for_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWAP) |-> ((out_valid && out_ready) == (in_valid && in_ready)));

    a_r5_drain_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |-> !in_ready);

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH && out_valid && !out_ready) |=> (out_valid && $stable(idx)));

    a_r6_done_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(out_valid && out_ready) || $past(start)));

    a_r9_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_like && !step) |=> $stable(blk_left));

endmodule

// File: rtl/brr_bank.sv
module brr_bank
    import brr_pkg::*;
#(
    parameter int DW  = 16,
    parameter int NU  = 4,
    parameter int ETA = 1
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic                  wr_bank,
    input  logic [NU-ETA-1:0]     wr_idx,
    input  logic [(DW<<ETA)-1:0]  wr_data,
    input  logic                  rd_bank,
    input  logic [NU-ETA-1:0]     rd_idx,
    output logic [(DW<<ETA)-1:0]  rd_data
);
    localparam int M = 1 << NU;
    localparam int C = 1 << ETA;

    logic [DW-1:0] mem [2][M];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int j = 0; j < C; j++) begin
                mem[wr_bank][{wr_idx, ETA'(j)}] <= wr_data[j*DW +: DW];
            end
        end
    end

    for (genvar j = 0; j < C; j++) begin : g_lane
        logic [NU-1:0] lin_addr, rev_addr;
        logic [15:0]   rev_full;
        assign lin_addr = {rd_idx, ETA'(j)};
        assign rev_full = rev_bits(16'(lin_addr), NU);
        assign rev_addr = rev_full[NU-1:0];
        assign rd_data[j*DW +: DW] = mem[rd_bank][rev_addr];
    end

endmodule

// File: rtl/brev_stream.sv
module brev_stream #(
    parameter int DW  = 16,
    parameter int NU  = 4,
    parameter int ETA = 1,
    parameter int BW  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [BW-1:0]         num_blocks,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [(DW<<ETA)-1:0]  in_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [(DW<<ETA)-1:0]  out_data,
    output logic                  done
);
    localparam int IW = NU - ETA;

    logic          wr_en, wr_bank, rd_bank;
    logic [IW-1:0] chunk_idx;

    brr_ctrl #(.NU(NU), .ETA(ETA), .BW(BW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .num_blocks (num_blocks),
        .in_valid   (in_valid),
        .out_ready  (out_ready),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .done       (done),
        .wr_en      (wr_en),
        .wr_bank    (wr_bank),
        .rd_bank    (rd_bank),
        .chunk_idx  (chunk_idx)
    );

    brr_bank #(.DW(DW), .NU(NU), .ETA(ETA)) u_bank (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_idx  (chunk_idx),
        .wr_data (in_data),
        .rd_bank (rd_bank),
        .rd_idx  (chunk_idx),
        .rd_data (out_data)
    );

endmodule

// File: tb/brev_stream_test.sv
module brev_stream_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 16;
    localparam int NU  = 4;
    localparam int ETA = 1;
    localparam int BW  = 16;
    localparam int C   = 1 << ETA;
    localparam int CPB = (1 << NU) / C;

    logic clk = 0, rst_n = 0, start = 0, in_valid = 0, out_ready = 1;
    logic [BW-1:0] num_blocks = '0;
    logic [C*DW-1:0] in_data = '0;
    logic in_ready, out_valid, done;
    logic [C*DW-1:0] out_data;

    int checks = 0, errors = 0, out_cnt = 0, phase = 0;
    bit rdy_rand = 0, stall_prev = 0;
    logic [C*DW-1:0] stall_data;
    logic [C*DW-1:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    brev_stream #(.DW(DW), .NU(NU), .ETA(ETA), .BW(BW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .num_blocks(num_blocks),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done)
    );

    function automatic logic [DW-1:0] sval(int r, int b, int i);
        return {4'(r), 4'(b), 4'(~i), 4'(i)};
    endfunction

    function automatic int rev(int v);
        int r = 0;
        for (int i = 0; i < NU; i++) if (v[i]) r |= 1 << (NU - 1 - i);
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ready pattern
    always @(posedge clk) begin
        #1;
        out_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (phase == 1) check(!out_valid, "R3 no output in block 0", 64'(out_valid), 0);
            if (phase == 2) check(out_valid == in_valid, "R4 valid follows input", 64'(out_valid), 64'(in_valid));
            if (phase == 3) check(!in_ready, "R5 input closed in drain", 64'(in_ready), 0);
            if (stall_prev)
                check(out_valid && out_data == stall_data, "R8 stall hold", 64'(out_data), 64'(stall_data));
            stall_prev = out_valid && !out_ready;
            stall_data = out_data;
            if (out_valid && out_ready) begin
                out_cnt++;
                if (exp_q.size() == 0) check(0, "R6 extra chunk", 64'(out_data), 0);
                else begin
                    logic [C*DW-1:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e, "R2 reversed order", 64'(out_data), 64'(e));
                end
            end
        end
    end

    task automatic do_reset();
        rst_n = 0; phase = 0; in_valid = 0; start = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(!in_ready && !out_valid && !done, "R1 reset state",
              64'({in_ready, out_valid, done}), 0);
    endtask

    task automatic do_start(int n);
        @(posedge clk); #1;
        start = 1; num_blocks = BW'(n);
        @(posedge clk); #1;
        start = 0;
    endtask

    task automatic send_run(int r, int n, bit gaps, bit glitch);
        for (int b = 0; b < n; b++) begin
            for (int q = 0; q < CPB; q++)
                exp_q.push_back({sval(r, b, rev(q*C+1)), sval(r, b, rev(q*C))});
            phase = (b == 0) ? 1 : 2;
            for (int q = 0; q < CPB; q++) begin
                if (gaps && (q % 3 == 1)) begin
                    in_valid = 0;
                    @(posedge clk); #1;
                end
                in_valid = 1;
                in_data  = {sval(r, b, q*C+1), sval(r, b, q*C)};
                forever begin
                    @(negedge clk);
                    if (in_ready) break;
                end
                @(posedge clk); #1;
                if (glitch && b == 1 && q == 2) begin
                    in_valid = 0;
                    start = 1; num_blocks = BW'(7);
                    @(posedge clk); #1;
                    start = 0;
                end
            end
        end
        in_valid = 0;
        phase = 3;
    endtask

    task automatic wait_done(int n);
        int t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        phase = 0;
        check(done, "R6 done after drain", 64'(done), 1);
        check(out_cnt == n*CPB, "R6 output count", 64'(out_cnt), 64'(n*CPB));
        check(exp_q.size() == 0, "R6 all blocks drained", 64'(exp_q.size()), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // single block, no backpressure
        out_cnt = 0;
        do_start(1);
        check(!done, "R6 done low while running", 64'(done), 0);
        send_run(1, 1, 0, 0);
        wait_done(1);
        repeat (3) @(negedge clk);
        check(done, "R6 done held until start", 64'(done), 1);

        // three blocks, gaps and backpressure
        rdy_rand = 1; out_cnt = 0;
        do_start(3);
        check(!done, "R6 done cleared by start", 64'(done), 0);
        send_run(2, 3, 1, 0);
        wait_done(3);

        // four blocks with a stray start mid-run (R9)
        out_cnt = 0;
        do_start(4);
        send_run(3, 4, 0, 1);
        wait_done(4);
        check(out_cnt == 4*CPB, "R9 stray start ignored", 64'(out_cnt), 64'(4*CPB));

        // zero-count run
        rdy_rand = 0;
        do_reset();
        out_cnt = 0;
        do_start(0);
        @(negedge clk);
        check(done, "R7 zero count finishes", 64'(done), 1);
        repeat (5) @(negedge clk);
        check(out_cnt == 0, "R7 zero count emits nothing", 64'(out_cnt), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule